// File: doc/BRIEF.md
# Shared Ready-Strobe and Serial-Data Pin Controller

This block drives one output pin that does two jobs in turn. The pin runs on a fixed conversion cycle counted in system clocks. Near the end of each cycle, the pin is held high and the newest conversion result is copied into an output word. The pin then gives a short low pulse followed by a short high pulse, which tells a host that fresh data is ready. For the rest of the cycle, the same pin carries the output word serially, most significant bit first. Each falling edge of a serial clock supplied by the host advances the pin by one bit, so the host can latch each bit on the following rising edge.

The host serial clock is unrelated to the system clock. It is brought into the system clock domain through a short synchronizer, and only its falling edges are acted on. A result strobed in while the host may be reading is parked in a holding register. It is copied into the output word only when the next cycle opens, so a word that is being read never changes under the host. The host may read part of the word, all of it, or more than all of it, and each of these cases leaves the pin in a defined state.

Top module: `rdy_dout_pin_ctrl`

## Requirements
- R1: The pin sequence repeats every CYC system clocks (default 384). After reset is released, the first cycle begins at clock 0 of the write window.
- R2: Within each cycle, the pin is high on clocks 0–5 (write window). It is low on clocks 6–11 (ready pulse) and high on clocks 12–17. Clocks 18–359 are the data window.
- R3: The pin is high on the last 24 clocks of every cycle (clocks 360–383). No serial clock activity changes this.
- R4: At the start of the data window, with no serial clock activity, the pin shows bit 23 (the MSB) of the word loaded at that cycle's write window.
- R5: Each falling edge of the serial clock inside the data window moves the pin to the next lower bit. After k falling edges, the pin shows bit 23−k. The change appears at most four system clocks after the falling edge.
- R6: After fewer than 24 falling edges, the pin keeps the bit placed by the last edge until the data window ends.
- R7: From the 24th falling edge onward, the pin is low for the rest of the data window. Further edges change nothing.
- R8: The bit position restarts at the opening of the write window and at the start of the final 24-clock high window. Falling edges outside the data window are ignored, so the first bit of each data window is always the MSB of the current word.
- R9: A result strobed during a cycle is copied into the output word at clock 0 of the next cycle. If no result arrived, the previous word is sent again.
- R10: Results strobed during the data window do not change the bits being read. When several results arrive within a cycle, the last one is kept. A result strobed on clock 0 itself is loaded at once.
- R11: During and after reset, the pin is high, and the output word is zero until the first load.
- R12: A rising edge of the serial clock alone never moves the bit position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Host serial clock, asynchronous, idle low |
| result_i | input | W (24) | Conversion result word |
| result_stb_i | input | 1 | One-clock strobe marking result_i valid |
| pin_o | output | 1 | Shared ready-pulse and serial-data pin |

## Verification
Most internal faults in this block show up at the pin within one cycle. A cycle counter that is off by one moves the low pulse away from clock 6. A bit pointer that does not restart starts the next data window on a bit other than the MSB. A faulty holding register sends a stale word, or changes the word while it is being read. The bench compares the pin on every system clock against an independent model. An error in window timing is therefore caught on the first clock where it occurs. An error in the bit pointer is caught within four clocks of the serial-clock edge that exposes it.

// File: rtl/rdp_pkg.sv
package rdp_pkg;

  typedef enum logic [2:0] {
    WIN_WRITE,
    WIN_LOW,
    WIN_HIGH,
    WIN_DATA,
    WIN_PRE
  } win_e;

  // Window decode from the position inside the conversion cycle.
  function automatic win_e window_of(input int unsigned ph,
                                     input int unsigned t_wr,
                                     input int unsigned t_lo,
                                     input int unsigned t_hi,
                                     input int unsigned pre_start);
    if (ph < t_wr)                    return WIN_WRITE;
    else if (ph < t_wr + t_lo)        return WIN_LOW;
    else if (ph < t_wr + t_lo + t_hi) return WIN_HIGH;
    else if (ph < pre_start)          return WIN_DATA;
    return WIN_PRE;
  endfunction

  // Pin level for every window except the data window.
  function automatic logic ready_level(input win_e w);
    return (w != WIN_LOW);
  endfunction

endpackage

// File: rtl/rdp_timebase.sv
module rdp_timebase #(
  parameter int CYC   = 384,
  parameter int T_WR  = 6,
  parameter int T_LO  = 6,
  parameter int T_HI  = 6,
  parameter int T_PRE = 24,
  parameter int PH_W  = $clog2(CYC)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [PH_W-1:0]  phase_o,
  output rdp_pkg::win_e    win_o,
  output logic             write_start_o,
  output logic             pre_start_o
);
  localparam int PRE_START = CYC - T_PRE;

  logic [PH_W-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          phase_q <= '0;
    else if (phase_q == PH_W'(CYC - 1))  phase_q <= '0;
    else                                 phase_q <= phase_q + 1'b1;
  end

  always_comb begin
    win_o         = rdp_pkg::window_of(32'(phase_q), T_WR, T_LO, T_HI, PRE_START);
    write_start_o = (phase_q == '0);
    pre_start_o   = (phase_q == PH_W'(PRE_START));
  end

  assign phase_o = phase_q;

endmodule

// File: rtl/rdp_sclk_sync.sv
module rdp_sclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  output logic fall_o
);
  // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], sclk_i};
  end

  assign fall_o = chain[STAGES] & ~chain[STAGES-1];

endmodule

// File: rtl/rdp_word_shift.sv
module rdp_word_shift #(
  parameter int W     = 24,
  parameter int PTR_W = $clog2(W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             write_start_i,
  input  logic             pre_start_i,
  input  logic             in_data_i,
  input  logic             fall_i,
  input  logic [W-1:0]     result_i,
  input  logic             stb_i,
  output logic [W-1:0]     word_o,
  output logic [PTR_W-1:0] ptr_o,
  output logic             load_o
);
  logic [W-1:0]     word_q, pend_q;
  logic             pend_v_q;
  logic [PTR_W-1:0] ptr_q;
  logic             at_end;

  assign at_end = (ptr_q == PTR_W'(W));
  assign load_o = write_start_i & (stb_i | pend_v_q);

  // Output word and holding register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q   <= '0;
      pend_q   <= '0;
      pend_v_q <= 1'b0;
    end else if (write_start_i) begin
      if (stb_i)         word_q <= result_i;
      else if (pend_v_q) word_q <= pend_q;
      pend_v_q <= 1'b0;
    end else if (stb_i) begin
      pend_q   <= result_i;
      pend_v_q <= 1'b1;
    end
  end

  // Bit pointer: restarts twice per cycle, saturates past the LSB
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              ptr_q <= '0;
    else if (write_start_i || pre_start_i)   ptr_q <= '0;
    else if (in_data_i && fall_i && !at_end) ptr_q <= ptr_q + 1'b1;
  end

  assign word_o = word_q;
  assign ptr_o  = ptr_q;

endmodule

// File: rtl/rdy_dout_pin_ctrl.sv
module rdy_dout_pin_ctrl #(
  parameter int W        = 24,
  parameter int CYC      = 384,
  parameter int T_WR     = 6,
  parameter int T_LO     = 6,
  parameter int T_HI     = 6,
  parameter int T_PRE    = 24,
  parameter int SYNC_STG = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk_i,
  input  logic [W-1:0] result_i,
  input  logic         result_stb_i,
  output logic         pin_o
);
  localparam int PH_W  = $clog2(CYC);
  localparam int PTR_W = $clog2(W + 1);
  localparam int IDX_W = $clog2(W);

  logic [PH_W-1:0]  phase_q;
  rdp_pkg::win_e    win;
  logic             write_start, pre_start, in_data;
  logic             sclk_fall;
  logic [W-1:0]     word_q;
  logic [PTR_W-1:0] ptr_q;
  logic             load_now;
  logic [IDX_W-1:0] bit_idx;
  logic             bit_sel;

  rdp_timebase #(
    .CYC(CYC), .T_WR(T_WR), .T_LO(T_LO), .T_HI(T_HI), .T_PRE(T_PRE), .PH_W(PH_W)
  ) u_tb (
    .clk(clk), .rst_n(rst_n), .phase_o(phase_q), .win_o(win),
    .write_start_o(write_start), .pre_start_o(pre_start)
  );

  rdp_sclk_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .fall_o(sclk_fall)
  );

  assign in_data = (win == rdp_pkg::WIN_DATA);

  rdp_word_shift #(.W(W), .PTR_W(PTR_W)) u_ws (
    .clk(clk), .rst_n(rst_n),
    .write_start_i(write_start), .pre_start_i(pre_start),
    .in_data_i(in_data), .fall_i(sclk_fall),
    .result_i(result_i), .stb_i(result_stb_i),
    .word_o(word_q), .ptr_o(ptr_q), .load_o(load_now)
  );

  always_comb begin
    bit_idx = IDX_W'(W - 1) - IDX_W'(ptr_q);
    bit_sel = word_q[bit_idx];
    if (in_data) pin_o = (ptr_q >= PTR_W'(W)) ? 1'b0 : bit_sel;
    else         pin_o = rdp_pkg::ready_level(win);
  end

endmodule

// File: rtl/rdp_pin_checker.sv
module rdp_pin_checker #(
  parameter int W     = 24,
  parameter int CYC   = 384,
  parameter int PH_W  = 9,
  parameter int PTR_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PH_W-1:0]  phase,
  input rdp_pkg::win_e    win,
  input logic [PTR_W-1:0] ptr,
  input logic [W-1:0]     word,
  input logic             load_now,
  input logic             sclk_fall,
  input logic             pin
);
  import rdp_pkg::*;

  p_phase_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_W'(CYC - 1)) |=> (phase == '0));

  p_phase_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_W'(CYC - 1)) |=> (phase == $past(phase) + 1'b1));

  p_ready_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (win == WIN_LOW) |-> !pin);

  p_ready_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (win == WIN_WRITE || win == WIN_HIGH) |-> pin);

  p_pre_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (win == WIN_PRE) |-> pin);

  p_msb_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (win == WIN_DATA && ptr == '0) |-> (pin == word[W-1]));

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (win == WIN_DATA && !sclk_fall) |=> (ptr == $past(ptr)));

  p_ptr_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= PTR_W'(W));

  p_over_read_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (win == WIN_DATA && ptr == PTR_W'(W)) |-> !pin);

  p_ptr_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (win == WIN_WRITE && phase == '0) |=> (ptr == '0));

  p_word_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !load_now |=> $stable(word));

endmodule

bind rdy_dout_pin_ctrl rdp_pin_checker #(
  .W(W), .CYC(CYC), .PH_W(PH_W), .PTR_W(PTR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .phase(phase_q), .win(win), .ptr(ptr_q),
  .word(word_q), .load_now(load_now), .sclk_fall(sclk_fall), .pin(pin_o)
);

// File: tb/tb_rdy_dout_pin_ctrl.sv
module tb_rdy_dout_pin_ctrl;
  localparam int W     = 24;
  localparam int CYC   = 384;
  localparam int T_PRE = 24;
  localparam int DSTART = 18;
  localparam int PSTART = CYC - T_PRE;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sclk = 1'b0;
  logic [W-1:0] res = '0;
  logic         stb = 1'b0;
  logic         pin;

  int n_chk = 0, n_fail = 0, cyc_cnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rdy_dout_pin_ctrl dut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .result_i(res),
    .result_stb_i(stb), .pin_o(pin)
  );

  // ---------------- behavioural reference ----------------
  int           m_ph, m_ptr;
  logic [W-1:0] m_word, m_pend;
  bit           m_pendv;
  bit           m_hist[$] = '{0, 0, 0};

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_ptr = 0; m_word = '0; m_pend = '0; m_pendv = 0;
      m_hist = '{0, 0, 0};
    end else begin
      int  old_ph;
      bit  fell;
      old_ph = m_ph;
      fell   = m_hist[2] && !m_hist[1];
      m_hist.push_front(sclk);
      void'(m_hist.pop_back());
      if (old_ph == 0 || old_ph == PSTART) m_ptr = 0;
      else if (old_ph >= DSTART && old_ph < PSTART && fell && m_ptr < W) m_ptr++;
      if (old_ph == 0) begin
        if (stb) m_word = res;
        else if (m_pendv) m_word = m_pend;
        m_pendv = 0;
      end else if (stb) begin
        m_pend = res; m_pendv = 1;
      end
      m_ph = (old_ph == CYC - 1) ? 0 : old_ph + 1;
    end
  end

  function automatic logic model_pin();
    if (m_ph < 6)       return 1'b1;
    if (m_ph < 12)      return 1'b0;
    if (m_ph < DSTART)  return 1'b1;
    if (m_ph < PSTART)  return (m_ptr >= W) ? 1'b0 : m_word[W-1-m_ptr];
    return 1'b1;
  endfunction

  function automatic string region_tag();
    if (m_ph < DSTART) return "R2";
    if (m_ph < PSTART) return "R5";
    return "R3";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // every-clock comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) check(region_tag(), 32'(pin), 32'(model_pin()));
  end

  // ---------------- stimulus helpers ----------------
  task automatic wait_ph(input int p);
    do @(negedge clk); while (m_ph != p);
  endtask

  task automatic strobe(input logic [W-1:0] d);
    res = d; stb = 1'b1;
    @(negedge clk);
    stb = 1'b0;
  endtask

  task automatic read_bits(input int n, output logic [W-1:0] cap);
    cap = '0;
    for (int k = 0; k < n; k++) begin
      repeat (4) @(negedge clk);
      cap = {cap[W-2:0], pin};
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt >= 100000 && !done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc_cnt, 100000);
      finish_run();
    end
  end

  // ---------------- test sequence ----------------
  localparam logic [W-1:0] W1 = 24'hB4E21D;
  localparam logic [W-1:0] W2 = 24'h5A3C96;
  localparam logic [W-1:0] W3 = 24'h123456;
  localparam logic [W-1:0] W4 = 24'hE1F00F;
  localparam logic [W-1:0] W5 = 24'h3CC3A5;

  initial begin
    logic [W-1:0] cap;
    repeat (3) @(negedge clk);
    check("R11", 32'(pin), 32'h1);            // high while in reset
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", 32'(pin), 32'h1);            // write window after release
    wait_ph(30);
    check("R11", 32'(pin), 32'h0);            // word still zero

    // R1: cycle length from one ready pulse to the next
    wait_ph(6);
    check("R1", 32'(pin), 32'h0);
    repeat (CYC - 1) @(negedge clk);
    check("R1", 32'(pin), 32'h1);
    @(negedge clk);
    check("R1", 32'(pin), 32'h0);

    wait_ph(100);
    strobe(W1);

    // idle data window shows new MSB; later strobe must not disturb it
    wait_ph(40);
    check("R4", 32'(pin), 32'(W1[W-1]));
    wait_ph(200);
    strobe(W2);
    wait_ph(300);
    check("R10", 32'(pin), 32'(W1[W-1]));

    // full read of the word loaded next cycle
    wait_ph(20);
    read_bits(24, cap);
    check("R5", 32'(cap), 32'(W2));
    wait_ph(300);
    check("R7", 32'(pin), 32'h0);

    // partial read of the same word sent again
    wait_ph(20);
    read_bits(10, cap);
    check("R9", 32'(cap), 32'(W2[W-1 -: 10]));
    wait_ph(300);
    check("R6", 32'(pin), 32'(W2[W-11]));

    // over-long read
    wait_ph(20);
    read_bits(30, cap);
    wait_ph(350);
    check("R7", 32'(pin), 32'h0);

    // edges during pre-high and write windows are ignored
    wait_ph(362);
    read_bits(4, cap);
    wait_ph(20);
    check("R8", 32'(pin), 32'(W2[W-1]));

    // several results in one cycle: last one wins
    wait_ph(100);
    strobe(W3);
    wait_ph(150);
    strobe(W4);
    wait_ph(20);
    read_bits(24, cap);
    check("R10", 32'(cap), 32'(W4));

    // strobe on clock 0 is loaded at once; rising edge alone moves nothing
    wait_ph(0);
    strobe(W5);
    wait_ph(20);
    sclk = 1'b1;
    wait_ph(60);
    check("R12", 32'(pin), 32'(W5[W-1]));
    sclk = 1'b0;
    wait_ph(80);
    check("R10", 32'(pin), 32'(W5[W-2]));

    repeat (10) @(negedge clk);
    finish_run();
  end

endmodule